// File: doc/BRIEF.md
# Banked Flash Write-Protect Register File

This block keeps write-protect state for an on-chip flash that is divided into 4 KB banks. Each of the three agents that can change the flash (the embedded controller, the host and the debugger) has its own array of protect bits, one bit per bank, packed eight banks to a byte. Software sets protect bits through a small register port. A bit once set stays set: no write can clear it, and a warm reset leaves it alone. Only the power-on reset returns the arrays to the unprotected state.

A lock bit freezes the whole configuration. After it is set, every further write to any protect array is dropped, so the protection map cannot grow or change until the next power-on reset.

Next to the register port sits an access checker. The flash controller presents a requester flag and the flash byte address of each write or erase request. In the same cycle, the block raises a block signal if the protect bit for that bank is set in that requester's array.

Top module: `wp_regfile`

## Requirements
- R1: The flash holds 256 banks of 4 KB. A check address selects its bank with address bits [19:12]. Bank b is held in byte index b/8 of a requester's array, at bit b%8.
- R2: A register address is 7 bits wide. Bits [6:5] choose the space (0 = embedded controller array, 1 = host array, 2 = debugger array, 3 = lock space), and bits [4:0] give the byte index. A write ORs the data byte into the addressed protect byte, and a zero data bit leaves the stored bit unchanged.
- R3: No register write clears a protect bit. A set bit stays set until power-on reset, so writing 0x00 over a set byte reads back the same value.
- R4: The lock bit sits at bit 0 of lock-space index 0. A write with data bit 0 equal to 1 sets it, and a write with data bit 0 equal to 0 has no effect. Once set, it stays set until power-on reset, and it reads back as 0x01.
- R5: While the lock bit is set, writes to all three protect arrays are ignored.
- R6: The requester flags are host = 0x1, debugger = 0x2 and embedded controller = 0x4. When chk_valid is high, chk_block rises in the same cycle if the bank bit is set in the array of any flagged requester. The arrays are independent, so a bit set in one array does not block another requester.
- R7: chk_block is low whenever chk_valid is low.
- R8: A read presented with rd_en returns rd_data together with rd_valid one clock later. Lock-space indices other than 0 read as 0x00.
- R9: The warm reset rst_n clears only rd_data and rd_valid. Protect bits and the lock bit survive it.
- R10: The power-on reset por_n asynchronously clears all protect bits, the lock bit and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| rst_n | input | 1 | Warm reset, active low; clears only the read outputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address {space, byte index} |
| wr_data | input | 8 | Write data; 1 bits set protect bits |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 7 | Register read address {space, byte index} |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read data |
| chk_valid | input | 1 | Access check request valid |
| chk_req | input | 3 | Requester flags (host 0x1, debugger 0x2, embedded controller 0x4) |
| chk_addr | input | 20 | Flash byte address of the request |
| chk_block | output | 1 | Request hits a protected bank (combinational) |

## Verification
The bench targets the bank edges: the last byte of bank 0 against the first byte of bank 1, and the top address of bank 255. A design with a wrong bank slice or bit order blocks the neighbouring bank or misses the protected one. It writes zero and partial bytes over set bytes; a design that stores the written byte instead of ORing it clears protection. It sets a bit in one requester's array and probes the others, which catches arrays that are crossed or shared. It also tries a lock write with bit 0 clear, protect writes after locking, and a warm reset pulse. A lock taken from the wrong data bit, a lock gate that does not work, or a warm reset that reaches the arrays each shows up as a wrong read-back value or a wrong block result.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
   localparam int NUM_REQ = 3;

   // array slot order; register space select uses the same numbering
   typedef enum logic [1:0] {
      SP_EC   = 2'd0,
      SP_HOST = 2'd1,
      SP_DBG  = 2'd2,
      SP_LOCK = 2'd3
   } space_e;

   // position of each requester's flag inside the chk_req vector
   function automatic int flag_bit(input int slot);
      case (slot)
         0:       return 2;   // embedded controller -> 0x4
         1:       return 0;   // host -> 0x1
         default: return 1;   // debugger -> 0x2
      endcase
   endfunction
endpackage

// File: rtl/wp_bank_array.sv
`timescale 1ns/1ps
module wp_bank_array #(
   parameter int NUM_BANKS = 256,
   localparam int NUM_BYTES = NUM_BANKS / 8,
   localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 set_en,
   input  logic [IDX_W-1:0]     set_idx,
   input  logic [7:0]           set_byte,
   input  logic                 frozen,
   output logic [NUM_BANKS-1:0] bits
);
   // bytes are laid out as separate sticky registers
   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic hit;
      assign hit = set_en && !frozen && (set_idx == IDX_W'(b));
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            bits[b*8 +: 8] <= 8'h00;
         else if (hit)
            bits[b*8 +: 8] <= bits[b*8 +: 8] | set_byte;
      end
   end
endmodule

// File: rtl/wp_lock_bit.sv
`timescale 1ns/1ps
module wp_lock_bit (
   input  logic clk,
   input  logic por_n,
   input  logic set_en,
   input  logic set_val,
   output logic locked
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         locked <= 1'b0;
      else if (set_en && set_val)
         locked <= 1'b1;
   end
endmodule

// File: rtl/wp_access_check.sv
`timescale 1ns/1ps
module wp_access_check
   import wp_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int BANK_SHIFT = 12,
   localparam int BANK_W    = ADDR_W - BANK_SHIFT,
   localparam int NUM_BANKS = 1 << BANK_W
) (
   input  logic                              chk_valid,
   input  logic [NUM_REQ-1:0]                chk_req,
   input  logic [ADDR_W-1:0]                 chk_addr,
   input  logic [NUM_REQ-1:0][NUM_BANKS-1:0] prot,
   output logic                              chk_block
);
   logic [BANK_W-1:0]  bank;
   logic [NUM_REQ-1:0] hit;

   assign bank = chk_addr[BANK_SHIFT +: BANK_W];

   for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
      assign hit[r] = chk_req[flag_bit(r)] && prot[r][bank];
   end

   assign chk_block = chk_valid && (|hit);
endmodule

// File: rtl/wp_regfile.sv
`timescale 1ns/1ps
module wp_regfile
   import wp_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int BANK_SHIFT = 12,
   localparam int BANK_W    = ADDR_W - BANK_SHIFT,
   localparam int NUM_BANKS = 1 << BANK_W,
   localparam int NUM_BYTES = NUM_BANKS / 8,
   localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
   localparam int REG_AW    = IDX_W + 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] rd_addr,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   input  logic              chk_valid,
   input  logic [NUM_REQ-1:0] chk_req,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic              chk_block
);
   // elaboration-time parameter checks
   if (BANK_W < 3) begin : g_bad_banks
      $error("wp_regfile: at least eight banks are required");
   end
   if (BANK_SHIFT < 1 || BANK_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("wp_regfile: BANK_SHIFT out of range");
   end

   logic [NUM_REQ-1:0][NUM_BANKS-1:0] prot_all;
   logic                              lock_q;

   space_e            wr_sp, rd_sp;
   logic [IDX_W-1:0]  wr_idx, rd_idx;

   assign wr_sp  = space_e'(wr_addr[REG_AW-1 -: 2]);
   assign wr_idx = wr_addr[IDX_W-1:0];
   assign rd_sp  = space_e'(rd_addr[REG_AW-1 -: 2]);
   assign rd_idx = rd_addr[IDX_W-1:0];

   // one sticky array per requester
   for (genvar r = 0; r < NUM_REQ; r++) begin : g_arr
      wp_bank_array #(.NUM_BANKS(NUM_BANKS)) u_arr (
         .clk      (clk),
         .por_n    (por_n),
         .set_en   (wr_en && (wr_sp == space_e'(r))),
         .set_idx  (wr_idx),
         .set_byte (wr_data),
         .frozen   (lock_q),
         .bits     (prot_all[r])
      );
   end

   wp_lock_bit u_lock (
      .clk     (clk),
      .por_n   (por_n),
      .set_en  (wr_en && (wr_sp == SP_LOCK) && (wr_idx == '0)),
      .set_val (wr_data[0]),
      .locked  (lock_q)
   );

   wp_access_check #(.ADDR_W(ADDR_W), .BANK_SHIFT(BANK_SHIFT)) u_chk (
      .chk_valid (chk_valid),
      .chk_req   (chk_req),
      .chk_addr  (chk_addr),
      .prot      (prot_all),
      .chk_block (chk_block)
   );

   // read path
   logic [7:0] rd_next;
   always_comb begin
      rd_next = 8'h00;
      if (rd_sp == SP_LOCK) begin
         if (rd_idx == '0) rd_next = {7'b0, lock_q};
      end else begin
         rd_next = prot_all[rd_sp][{rd_idx, 3'b000} +: 8];
      end
   end

   logic rd_rst_n;
   assign rd_rst_n = rst_n && por_n;

   always_ff @(posedge clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 8'h00;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_next;
      end
   end
endmodule

// File: rtl/wp_regfile_chk.sv
`timescale 1ns/1ps
module wp_regfile_chk
   import wp_pkg::*;
#(
   parameter int NUM_BANKS = 256,
   parameter int REG_AW    = 7
) (
   input logic                              clk,
   input logic                              por_n,
   input logic                              rst_n,
   input logic                              wr_en,
   input logic [REG_AW-1:0]                 wr_addr,
   input logic [7:0]                        wr_data,
   input logic                              rd_valid,
   input logic [7:0]                        rd_data,
   input logic                              chk_valid,
   input logic [NUM_REQ-1:0]                chk_req,
   input logic                              chk_block,
   input logic [NUM_REQ-1:0][NUM_BANKS-1:0] prot_all,
   input logic                              lock_q
);
   assert_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
      (($past(prot_all) & ~prot_all) == '0));

   assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> lock_q);

   assert_lock_cause_R4: assert property (@(posedge clk) disable iff (!por_n)
      $rose(lock_q) |-> $past(wr_en && (wr_addr[REG_AW-1 -: 2] == 2'd3) && wr_data[0]));

   assert_frozen_R5: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> $stable(prot_all));

   assert_needs_flag_R6: assert property (@(posedge clk) disable iff (!por_n)
      chk_block |-> (chk_req != '0));

   assert_idle_R7: assert property (@(posedge clk) disable iff (!por_n)
      !chk_valid |-> !chk_block);

   assert_warm_R9: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |-> (rd_data == 8'h00 && !rd_valid));
endmodule

bind wp_regfile wp_regfile_chk #(.NUM_BANKS(NUM_BANKS), .REG_AW(REG_AW)) u_wp_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .chk_valid (chk_valid),
   .chk_req   (chk_req),
   .chk_block (chk_block),
   .prot_all  (prot_all),
   .lock_q    (lock_q)
);

// File: tb/wp_regfile_tb.sv
`timescale 1ns/1ps
module wp_regfile_tb_top;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [6:0]  rd_addr = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        chk_valid = 1'b0;
   logic [2:0]  chk_req = '0;
   logic [19:0] chk_addr = '0;
   logic        chk_block;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   wp_regfile dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .chk_valid(chk_valid), .chk_req(chk_req), .chk_addr(chk_addr),
      .chk_block(chk_block)
   );

   // reference model built from the requirements
   logic [7:0] m_prot [3][32];
   logic       m_lock;

   task automatic model_clear();
      for (int s = 0; s < 3; s++)
         for (int i = 0; i < 32; i++) m_prot[s][i] = 8'h00;
      m_lock = 1'b0;
   endtask

   function automatic logic [7:0] model_read(input logic [1:0] sp, input logic [4:0] idx);
      if (sp == 2'd3) return (idx == 5'd0) ? {7'b0, m_lock} : 8'h00;
      return m_prot[sp][idx];
   endfunction

   // scoreboard
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always @(negedge clk) begin
      if (rd_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R8: unexpected read data act=%02h exp=none", rd_data);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               bad++;
               $display("FAIL %s: read act=%02h exp=%02h", t, rd_data, e);
            end
         end
      end
   end

   task automatic do_write(input logic [1:0] sp, input logic [4:0] idx, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {sp, idx}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (sp == 2'd3) begin
         if (idx == 5'd0 && d[0]) m_lock = 1'b1;
      end else if (!m_lock) begin
         m_prot[sp][idx] = m_prot[sp][idx] | d;
      end
   endtask

   task automatic do_read(input logic [1:0] sp, input logic [4:0] idx, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = {sp, idx};
      exp_q.push_back(model_read(sp, idx));
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic do_check(input logic v, input logic [2:0] req, input logic [19:0] a,
                           input logic exp, input string tag);
      @(negedge clk);
      chk_valid = v; chk_req = req; chk_addr = a;
      #1;
      total++;
      if (chk_block !== exp) begin
         bad++;
         $display("FAIL %s: block act=%0b exp=%0b (req=%0h addr=%05h)", tag, chk_block, exp, req, a);
      end
      chk_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;

      // R10: reset state
      do_read(2'd0, 5'd0, "R10");
      do_read(2'd3, 5'd0, "R10");
      do_check(1'b1, 3'h4, 20'h00000, 1'b0, "R6");

      // R1/R2: embedded controller byte 3 -> banks 24 and 26
      do_write(2'd0, 5'd3, 8'h05);
      do_check(1'b1, 3'h4, 20'h18000, 1'b1, "R1");
      do_check(1'b1, 3'h4, 20'h19ABC, 1'b0, "R1");
      do_check(1'b1, 3'h4, 20'h1AFFF, 1'b1, "R1");
      do_check(1'b1, 3'h1, 20'h18000, 1'b0, "R6");
      do_read(2'd0, 5'd3, "R2");
      do_write(2'd0, 5'd3, 8'h02);
      do_read(2'd0, 5'd3, "R2");
      do_write(2'd0, 5'd3, 8'h00);
      do_read(2'd0, 5'd3, "R3");

      // R1/R6: host top bank, debugger bank 0 edge
      do_write(2'd1, 5'd31, 8'h80);
      do_check(1'b1, 3'h1, 20'hFFFFF, 1'b1, "R1");
      do_check(1'b1, 3'h2, 20'hFFFFF, 1'b0, "R6");
      do_write(2'd2, 5'd0, 8'h01);
      do_check(1'b1, 3'h2, 20'h00FFF, 1'b1, "R1");
      do_check(1'b1, 3'h2, 20'h01000, 1'b0, "R1");
      do_check(1'b1, 3'h3, 20'h00010, 1'b1, "R6");
      do_check(1'b0, 3'h2, 20'h00010, 1'b0, "R7");
      do_read(2'd1, 5'd31, "R2");
      do_read(2'd2, 5'd0, "R2");

      // R9: warm reset clears read outputs only
      do_read(2'd0, 5'd3, "R9");
      settle();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      total++;
      if (rd_data !== 8'h00 || rd_valid !== 1'b0) begin
         bad++;
         $display("FAIL R9: read outputs during warm reset act=%02h/%0b exp=00/0", rd_data, rd_valid);
      end
      @(negedge clk);
      rst_n = 1'b1;
      do_read(2'd0, 5'd3, "R9");
      do_check(1'b1, 3'h1, 20'hFF000, 1'b1, "R9");

      // R4/R8: lock behaviour
      do_write(2'd3, 5'd0, 8'hFE);
      do_read(2'd3, 5'd0, "R4");
      do_write(2'd0, 5'd5, 8'h10);
      do_write(2'd3, 5'd0, 8'h01);
      do_read(2'd3, 5'd0, "R4");
      do_read(2'd3, 5'd1, "R8");

      // R5: protect writes ignored after lock
      do_write(2'd0, 5'd5, 8'hFF);
      do_write(2'd1, 5'd0, 8'hFF);
      do_read(2'd0, 5'd5, "R5");
      do_read(2'd1, 5'd0, "R5");
      do_check(1'b1, 3'h1, 20'h00000, 1'b0, "R5");
      do_check(1'b1, 3'h4, 20'h2C000, 1'b1, "R5");
      do_write(2'd3, 5'd0, 8'h00);
      do_read(2'd3, 5'd0, "R4");

      // R10: power-on reset clears everything
      settle();
      @(negedge clk);
      por_n = 1'b0;
      model_clear();
      @(negedge clk);
      por_n = 1'b1;
      do_read(2'd0, 5'd3, "R10");
      do_read(2'd3, 5'd0, "R10");
      do_check(1'b1, 3'h1, 20'hFFFFF, 1'b0, "R10");
      do_write(2'd1, 5'd2, 8'h01);
      do_read(2'd1, 5'd2, "R10");

      settle();
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R8: %0d reads never returned act=%0d exp=0", exp_q.size(), exp_q.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog: run hung act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule